// File: doc/BRIEF.md
# Interrupt Nesting Status Controller

This block tracks how deeply the processor is nested in interrupt service. It uses a 2-bit nesting level with three legal values and decides, for each incoming request, whether the request may be taken. The decision uses the request's priority class and a global enable. When a request is taken, the current level goes onto a small internal LIFO and the level moves up by one step. A return strobe pops the LIFO and restores the level that was in force before that interrupt. Software may also load the level directly, which is meant to be done only while the global enable is low.

The level is the block's state machine. `LVL_IDLE` (code 00) is normal processing. `LVL_ANY` (code 01) means an interrupt of either class is in service. `LVL_HIGH` (code 10) means a high-class interrupt is in service. There are three kinds of transition. An *advance* moves IDLE to ANY or ANY to HIGH when a request is granted. A *restore* loads the popped level, or IDLE on underflow, when the return strobe is seen. A *load* takes a software-written legal code. In every other case the machine holds its level.

Top module: `intr_nest_ctrl`

## Requirements
- R1: While reset is low and just after it is released, `level` reads 00, the LIFO is empty, and `accept`, `accept_high` and `underflow` are all 0.
- R2: At level 00 a valid request is granted whatever its class, where `req_high`=0 means low class and `req_high`=1 means high class.
- R3: At level 01 only a high-class request is granted. At level 10 no request is granted.
- R4: `level` never holds 11. A software load of 11 is ignored and the level stays as it was.
- R5: A grant pushes the current level and advances the level by exactly one step at the same clock edge. For the cycle after that edge, `accept` is 1 and `accept_high` carries the class of the granted request.
- R6: While `gie` is 0 no request is granted.
- R7: A return strobe restores the level that was saved by the most recent unreturned grant. With the LIFO empty, the strobe sets the level to 00 and pulses `underflow` for one cycle.
- R8: When the LIFO holds DEPTH entries, no request is granted.
- R9: When several events coincide, the return strobe wins over a grant, and a grant wins over a software load. A software load of 00, 01 or 10 takes effect at the clock edge where it is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| gie | input | 1 | Global interrupt enable |
| req_valid | input | 1 | An interrupt request is present |
| req_high | input | 1 | Class of the request: 1 high, 0 low |
| rti | input | 1 | Return-from-interrupt strobe |
| sw_we | input | 1 | Software load strobe for the level |
| sw_data | input | 2 | Level value to load |
| level | output | 2 | Current nesting level |
| accept | output | 1 | One-cycle grant pulse |
| accept_high | output | 1 | Class of the granted request |
| underflow | output | 1 | One-cycle pulse when a return finds the LIFO empty |

## Verification
The hardest case to reach is a full LIFO. Normal nesting stops at level 10, so only two grants can be pushed before the level blocks further grants. The bench gets past this by alternating grants with software loads of 00 made under a low `gie`. Each load reopens the machine while the saved entries stay in place, and after DEPTH such grants one more request must be refused. Underflow is reached by issuing more returns than grants. Coincident events are covered by a sweep over every input combination from each legal level.

// File: rtl/intr_nest_pkg.sv
package intr_nest_pkg;
    typedef enum logic [1:0] {
        LVL_IDLE = 2'b00,
        LVL_ANY  = 2'b01,
        LVL_HIGH = 2'b10
    } nest_lvl_e;
endpackage

// File: rtl/intr_nest_gate.sv
module intr_nest_gate
    import intr_nest_pkg::*;
(
    input  nest_lvl_e level,
    input  logic      gie,
    input  logic      req_valid,
    input  logic      req_high,
    input  logic      room,
    output logic      grant
);
    logic class_ok;

    always_comb begin
        unique case (level)
            LVL_IDLE: class_ok = 1'b1;
            LVL_ANY:  class_ok = req_high;
            LVL_HIGH: class_ok = 1'b0;
            default:  class_ok = 1'b0;
        endcase
    end

    assign grant = gie & req_valid & room & class_ok;
endmodule

// File: rtl/intr_nest_stack.sv
module intr_nest_stack #(
    parameter int DEPTH = 4,
    parameter int W     = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic         pop,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout,
    output logic         empty,
    output logic         full
);
    localparam int CW = $clog2(DEPTH + 1);

    logic [CW-1:0] cnt;
    logic [W-1:0]  mem [DEPTH];
    logic          do_push;
    logic          do_pop;

    assign empty   = (cnt == '0);
    assign full    = (cnt == CW'(DEPTH));
    assign do_pop  = pop & ~empty;
    assign do_push = push & ~pop & ~full;

    always_ff @(posedge clk) begin
        if (!rst_n)       cnt <= '0;
        else if (do_pop)  cnt <= cnt - 1'b1;
        else if (do_push) cnt <= cnt + 1'b1;
    end

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (do_push && cnt == CW'(i)) mem[i] <= din;
        end
    end

    always_comb begin
        dout = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (cnt == CW'(i + 1)) dout = mem[i];
        end
    end
endmodule

// File: rtl/intr_nest_ctrl.sv
module intr_nest_ctrl
    import intr_nest_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       gie,
    input  logic       req_valid,
    input  logic       req_high,
    input  logic       rti,
    input  logic       sw_we,
    input  logic [1:0] sw_data,
    output logic [1:0] level,
    output logic       accept,
    output logic       accept_high,
    output logic       underflow
);
    localparam int LW = 2;

    nest_lvl_e      lvl_q, lvl_d;
    logic           grant, take;
    logic           stk_empty, stk_full;
    logic [LW-1:0]  stk_top;

    intr_nest_gate u_gate (
        .level     (lvl_q),
        .gie       (gie),
        .req_valid (req_valid),
        .req_high  (req_high),
        .room      (~stk_full),
        .grant     (grant)
    );

    assign take = grant & ~rti;

    intr_nest_stack #(.DEPTH(DEPTH), .W(LW)) u_stack (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (take),
        .pop   (rti),
        .din   (lvl_q),
        .dout  (stk_top),
        .empty (stk_empty),
        .full  (stk_full)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) lvl_q <= LVL_IDLE;
        else        lvl_q <= lvl_d;
    end

    // next state: restore > advance > load > hold
    always_comb begin
        lvl_d = lvl_q;
        if (rti) begin
            lvl_d = stk_empty ? LVL_IDLE : nest_lvl_e'(stk_top);
        end else if (take) begin
            unique case (lvl_q)
                LVL_IDLE: lvl_d = LVL_ANY;
                LVL_ANY:  lvl_d = LVL_HIGH;
                default:  lvl_d = lvl_q;
            endcase
        end else if (sw_we && sw_data != 2'b11) begin
            lvl_d = nest_lvl_e'(sw_data);
        end
    end

    // outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            accept      <= 1'b0;
            accept_high <= 1'b0;
            underflow   <= 1'b0;
        end else begin
            accept      <= take;
            accept_high <= take & req_high;
            underflow   <= rti & stk_empty;
        end
    end

    assign level = lvl_q;
endmodule

// File: rtl/intr_nest_chk.sv
module intr_nest_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       gie,
    input logic [1:0] level,
    input logic       accept,
    input logic       accept_high,
    input logic       underflow
);
    AST_LEVEL_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        level != 2'b11); // R4
    AST_ADVANCE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        accept |-> (level == $past(level) + 2'd1)); // R5
    AST_LOW_FROM_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !accept_high) |-> ($past(level) == 2'b00)); // R2
    AST_TOP_CLOSED: assert property (@(posedge clk) disable iff (!rst_n)
        accept |-> ($past(level) != 2'b10)); // R3
    AST_GIE_GATES: assert property (@(posedge clk) disable iff (!rst_n)
        accept |-> $past(gie)); // R6
    AST_UNDERFLOW_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        underflow |-> (level == 2'b00 && !accept)); // R7
endmodule

bind intr_nest_ctrl intr_nest_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .gie         (gie),
    .level       (level),
    .accept      (accept),
    .accept_high (accept_high),
    .underflow   (underflow)
);

// File: tb/sim_intr_nest_ctrl.sv
module sim_intr_nest_ctrl;
    localparam int DEPTH = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       gie = 1'b0, req_valid = 1'b0, req_high = 1'b0, rti = 1'b0, sw_we = 1'b0;
    logic [1:0] sw_data = 2'b00;
    logic [1:0] level;
    logic       accept, accept_high, underflow;

    int checks = 0;
    int errors = 0;
    int mlvl, mcnt;
    int mstk [DEPTH];
    bit macc, macch, muf;

    always #10 clk = ~clk;

    intr_nest_ctrl #(.DEPTH(DEPTH)) u0 (
        .clk(clk), .rst_n(rst_n), .gie(gie), .req_valid(req_valid),
        .req_high(req_high), .rti(rti), .sw_we(sw_we), .sw_data(sw_data),
        .level(level), .accept(accept), .accept_high(accept_high),
        .underflow(underflow)
    );

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic compare(input string tag);
        chk(tag, "level", int'(level), mlvl);
        chk(tag, "accept", int'(accept), int'(macc));
        chk(tag, "accept_high", int'(accept_high), int'(macch));
        chk(tag, "underflow", int'(underflow), int'(muf));
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; gie = 0; req_valid = 0; req_high = 0; rti = 0; sw_we = 0; sw_data = 0;
        repeat (2) @(negedge clk);
        mlvl = 0; mcnt = 0; macc = 0; macch = 0; muf = 0;
        compare("R1 in reset");
        rst_n = 1'b1;
        @(negedge clk);
        compare("R1 after release");
    endtask

    task automatic step(input bit g, input bit v, input bit h, input bit r,
                        input bit w, input logic [1:0] d, input string tag);
        bit ok, grant;
        gie = g; req_valid = v; req_high = h; rti = r; sw_we = w; sw_data = d;
        ok    = (mlvl == 0) || (mlvl == 1 && h);
        grant = g && v && ok && (mcnt < DEPTH);
        macc = 0; macch = 0; muf = 0;
        if (r) begin
            if (mcnt == 0) begin mlvl = 0; muf = 1; end
            else begin mcnt--; mlvl = mstk[mcnt]; end
        end else if (grant) begin
            mstk[mcnt] = mlvl; mcnt++; mlvl++; macc = 1; macch = h;
        end else if (w && d != 2'b11) begin
            mlvl = int'(d);
        end
        @(posedge clk);
        @(negedge clk);
        gie = 0; req_valid = 0; req_high = 0; rti = 0; sw_we = 0;
        compare(tag);
    endtask

    initial begin
        #3000000;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        // R2 R3 R6 R9: every input combination from each legal level
        for (int lv = 0; lv < 3; lv++)
            for (int c = 0; c < 128; c++) begin
                do_reset();
                if (lv > 0) step(0, 0, 0, 0, 1, 2'(lv), "R9 load");
                step(c[0], c[1], c[2], c[3], c[4], c[6:5],
                     lv == 0 ? "R2/R6/R9 sweep" : "R3/R6/R9 sweep");
            end

        // R5 nesting and R7 restore / underflow
        do_reset();
        step(1, 1, 0, 0, 0, 0, "R5 low grant");
        step(1, 1, 1, 0, 0, 0, "R5 high grant");
        step(1, 1, 1, 0, 0, 0, "R3 top closed");
        step(0, 0, 0, 1, 0, 0, "R7 restore 01");
        step(0, 0, 0, 1, 0, 0, "R7 restore 00");
        step(0, 0, 0, 1, 0, 0, "R7 underflow");
        step(0, 0, 0, 0, 0, 0, "R7 underflow one cycle");

        // R4 load of 11 ignored
        step(0, 0, 0, 0, 1, 2'b01, "R9 load 01");
        step(0, 0, 0, 0, 1, 2'b11, "R4 ignore 11");
        step(0, 0, 0, 0, 1, 2'b10, "R9 load 10");
        step(0, 0, 0, 0, 1, 2'b11, "R4 ignore 11 at 10");

        // R8 fill the LIFO by reopening with loads
        do_reset();
        for (int k = 0; k < DEPTH; k++) begin
            step(1, 1, 0, 0, 0, 0, "R8 fill grant");
            step(0, 0, 0, 0, 1, 2'b00, "R8 reopen");
        end
        step(1, 1, 1, 0, 0, 0, "R8 full blocks");
        for (int k = 0; k < DEPTH; k++) step(0, 0, 0, 1, 0, 0, "R7 drain");
        step(0, 0, 0, 1, 0, 0, "R7 drain underflow");
        step(1, 1, 0, 1, 1, 2'b10, "R9 return wins");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule